// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

A small up-counter stage with a parallel preset, an active-low master clear, two count enables and a terminal-count flag. Several stages chain into a wider counter: the terminal-count output of one stage feeds the tracking enable (`en_b`) of the next stage, and a shared run signal drives every `en_a`. Because the flag is combinational from `en_b` and the stored count, the whole chain advances in the same clock cycle, with no carry lag.

Two parameters pick the variant. `ASYNC_CLR` makes the clear act at once, without a clock edge, or at the next rising edge. `DECADE` picks a modulus of ten in place of two to the power `WIDTH`. Each cycle an action decoder picks one of four actions, in falling priority: `ACT_CLEAR` (clear, synchronous variant only), `ACT_LOAD` (preset from `din`), `ACT_COUNT` (advance) and `ACT_HOLD` (keep the value). In the asynchronous variant the clear bypasses the decoder and acts on the register directly. The count state moves on two transitions: increment (q to q+1) and fold (q to 0). Fold is taken at the top count, and in decade mode also from any value of 10 to 15.

Top module: `presettable_counter`

## Requirements
- R1: A low `clr_n` sets `q` to 0 whatever the levels of `load_n`, `en_a`, `en_b` and `din`.
- R2: With `ASYNC_CLR`=1, `q` reads 0 as soon as `clr_n` falls, with no clock edge. With `ASYNC_CLR`=0, `q` keeps its value until the next rising edge of `clk`.
- R3: A low `load_n` at a rising edge copies `din` into `q`. The load takes priority over both count enables.
- R4: When `load_n`, `en_a` and `en_b` are all high at a rising edge, `q` goes up by one.
- R5: When `load_n` is high and either `en_a` or `en_b` is low, `q` keeps its value.
- R6: The top count is 15 in binary mode and 9 in decade mode. A count from the top value gives 0.
- R7: `tc` is 1 exactly when `en_b` is 1 and `q` equals the top count. A low `en_a` alone does not clear `tc`. While a stage counts without a break, `tc` is high for one cycle only.
- R8: In decade mode, counting from any value of 10 to 15 gives 0 after one count.
- R9: In a chain where each stage's `tc` drives the next stage's `en_b`, N stages count modulo 10^N (decade) or 16^N (binary) with every stage updating in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action except the asynchronous clear takes place on its rising edge |
| clr_n | input | 1 | Master clear, active low |
| load_n | input | 1 | Parallel preset enable, active low |
| en_a | input | 1 | Count enable that does not affect `tc` |
| en_b | input | 1 | Count enable that also gates `tc` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
A wrong action choice appears on `q` at the rising edge where it is taken, and the next sample shows it. Examples are a load that loses to a count, a hold that counts, or a clear that waits for the clock in the asynchronous variant. A fold error shows up at the first count from the top value or from an illegal decade value. In a chain, it shows up at once as a wrong carry into the next stage. A fault in the terminal-count path shows up on `tc` in the same cycle. In a long cascade run it also makes the upper digits drift away from the running cycle count within one full turn of the lowest stage.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;
endpackage

// File: rtl/cnt_action_dec.sv
module cnt_action_dec
    import cnt_pkg::*;
#(
    parameter bit SYNC_CLR = 1'b1
) (
    input  logic     clr_n,
    input  logic     load_n,
    input  logic     en_a,
    input  logic     en_b,
    output cnt_act_e act
);
    logic clr_hit;

    assign clr_hit = SYNC_CLR && !clr_n;

    // Priority: clear, then load, then count, then hold
    always_comb begin
        act = ACT_HOLD;
        unique casez ({clr_hit, ~load_n, en_a & en_b})
            3'b1??:  act = ACT_CLEAR;
            3'b01?:  act = ACT_LOAD;
            3'b001:  act = ACT_COUNT;
            3'b000:  act = ACT_HOLD;
            default: act = ACT_HOLD;
        endcase
    end
endmodule

// File: rtl/cnt_step.sv
module cnt_step #(
    parameter int WIDTH = 4,
    parameter int MAXV  = 15
) (
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_inc
);
    localparam logic [WIDTH-1:0] MAXQ = WIDTH'(MAXV);

    // Fold to zero at the top count and from any value above it
    always_comb begin
        if (q >= MAXQ) q_inc = '0;
        else           q_inc = q + 1'b1;
    end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
    parameter int WIDTH = 4,
    parameter int MAXV  = 15
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_b,
    output logic             tc
);
    localparam logic [WIDTH-1:0] MAXQ = WIDTH'(MAXV);

    assign tc = en_b && (q == MAXQ);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0,
    parameter bit DECADE    = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_a,
    input  logic             en_b,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             tc
);
    localparam int             MAXV = DECADE ? 9 : (2 ** WIDTH) - 1;
    localparam logic [WIDTH-1:0] MAXQ = WIDTH'(MAXV);

    cnt_act_e         act;
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_inc;
    logic [WIDTH-1:0] q_nxt;

    cnt_action_dec #(.SYNC_CLR(!ASYNC_CLR)) u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_a   (en_a),
        .en_b   (en_b),
        .act    (act)
    );

    cnt_step #(.WIDTH(WIDTH), .MAXV(MAXV)) u_step (
        .q     (q_r),
        .q_inc (q_inc)
    );

    cnt_term #(.WIDTH(WIDTH), .MAXV(MAXV)) u_term (
        .q    (q_r),
        .en_b (en_b),
        .tc   (tc)
    );

    // Next-value selection per action
    always_comb begin
        q_nxt = q_r;
        unique case (act)
            ACT_CLEAR: q_nxt = '0;
            ACT_LOAD:  q_nxt = din;
            ACT_COUNT: q_nxt = q_inc;
            ACT_HOLD:  q_nxt = q_r;
            default:   q_nxt = q_r;
        endcase
    end

    // Count register: clear style chosen by parameter
    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q_r <= '0;
                else        q_r <= q_nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end
    endgenerate

    assign q = q_r;

    // R1: a clear seen at an edge leaves zero by the following edge
    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R3: a preset wins over the enables
    a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R4, R6: advance by one or fold to zero
    a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_a && en_b) |=>
            (q == (($past(q) >= MAXQ) ? '0 : WIDTH'($past(q) + 1'b1))));

    // R5: hold when an enable is low
    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_a && en_b)) |=> $stable(q));

    // R7: flag only with tracking enable and top count; single-cycle while counting
    a_r7_tc_cond: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (en_b && (q == MAXQ)));
    a_r7_tc_pulse: assert property (@(posedge clk) disable iff (!clr_n)
        (tc && en_a && load_n) |=> !tc);

    // R8: illegal decade values rejoin at zero
    a_r8_illegal_fold: assert property (@(posedge clk) disable iff (!clr_n)
        (DECADE && (q > MAXQ) && load_n && en_a && en_b) |=> (q == '0));
endmodule

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // u0: binary, synchronous clear
    logic       clr_n, load_n, en_a, en_b;
    logic [3:0] din, q;
    logic       tc;

    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b0)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_a(en_a), .en_b(en_b),
        .din(din), .q(q), .tc(tc)
    );

    // Three-stage decade chain, asynchronous clear
    logic       c_clr_n, c_load_n, run;
    logic [3:0] d0, d1, d2, q0, q1, q2;
    logic       tc0, tc1, tc2;

    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b1)) u_c0 (
        .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .en_a(run), .en_b(run),
        .din(d0), .q(q0), .tc(tc0)
    );
    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b1)) u_c1 (
        .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .en_a(run), .en_b(tc0),
        .din(d1), .q(q1), .tc(tc1)
    );
    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b1)) u_c2 (
        .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .en_a(run), .en_b(tc1),
        .din(d2), .q(q2), .tc(tc2)
    );

    // {clr_n, load_n, en_a, en_b, din[3:0], exp_q[3:0], exp_tc}
    localparam int NV = 11;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_0_1_1_1101_1101_0,  // R3 load 13
        13'b1_1_1_1_0000_1110_0,  // R4 count
        13'b1_1_1_1_0000_1111_1,  // R7 top count flags
        13'b1_1_1_1_0000_0000_0,  // R6 wrap 15 -> 0
        13'b1_0_1_0_1111_1111_0,  // R7 flag needs en_b
        13'b1_1_0_1_0000_1111_1,  // R5 hold, R7 en_a low keeps flag
        13'b1_1_1_0_0000_1111_0,  // R5 hold with en_b low
        13'b1_0_1_1_0101_0101_0,  // R3 load beats count
        13'b0_0_1_1_1001_0000_0,  // R1 clear beats load
        13'b1_1_1_1_0000_0001_0,  // R4 count from zero
        13'b1_1_0_0_0111_0001_0   // R5 hold, din ignored
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int chain_val();
        return int'(q2) * 100 + int'(q1) * 10 + int'(q0);
    endfunction

    initial begin
        clr_n = 1'b0; load_n = 1'b1; en_a = 1'b0; en_b = 1'b0; din = 4'd0;
        c_clr_n = 1'b0; c_load_n = 1'b1; run = 1'b0;
        d0 = 4'd0; d1 = 4'd0; d2 = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset u0", int'(q), 0);
        check("R1 reset chain", chain_val(), 0);
        @(negedge clk);
        clr_n = 1'b1; c_clr_n = 1'b1;

        // Vector table on u0
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {clr_n, load_n, en_a, en_b, din} = VEC[i][12:5];
            @(posedge clk);
            #1;
            check($sformatf("R3/R4/R5 vector %0d q", i), int'(q), int'(VEC[i][4:1]));
            check($sformatf("R7 vector %0d tc", i), int'(tc), int'(VEC[i][0]));
        end

        // R2 synchronous clear waits for the edge
        @(negedge clk);
        clr_n = 1'b1; load_n = 1'b0; din = 4'd6; en_a = 1'b0; en_b = 1'b0;
        @(posedge clk);
        @(negedge clk);
        load_n = 1'b1; clr_n = 1'b0;
        #2;
        check("R2 sync clear before edge", int'(q), 6);
        @(posedge clk);
        #1;
        check("R2 sync clear at edge", int'(q), 0);
        @(negedge clk);
        clr_n = 1'b1;

        // R9 cascade run through a full wrap
        run = 1'b1;
        for (int n = 1; n <= 1005; n++) begin
            @(posedge clk);
            #1;
            check("R9 cascade value", chain_val(), n % 1000);
            if ((n % 1000) == 999)
                check("R9 chain carry at 999", int'(tc2), 1);
        end

        // R2 asynchronous clear acts without an edge
        @(negedge clk);
        run = 1'b0;
        #1;
        c_clr_n = 1'b0;
        #1;
        check("R2 async clear no edge", chain_val(), 0);
        @(negedge clk);
        c_clr_n = 1'b1;

        // R8 illegal decade values
        @(negedge clk);
        c_load_n = 1'b0; d0 = 4'd12;
        @(posedge clk);
        #1;
        check("R3 decade load 12", int'(q0), 12);
        @(negedge clk);
        c_load_n = 1'b1; run = 1'b1;
        #1;
        check("R7 no flag in illegal state", int'(tc0), 0);
        @(posedge clk);
        #1;
        check("R8 12 folds to 0", int'(q0), 0);
        check("R8 no carry from 12", int'(q1), 0);
        @(negedge clk);
        run = 1'b0; c_load_n = 1'b0; d0 = 4'd15;
        @(posedge clk);
        @(negedge clk);
        c_load_n = 1'b1; run = 1'b1;
        @(posedge clk);
        #1;
        check("R8 15 folds to 0", int'(q0), 0);
        @(negedge clk);
        run = 1'b0; c_load_n = 1'b0; d0 = 4'd9;
        @(posedge clk);
        @(negedge clk);
        c_load_n = 1'b1; run = 1'b1;
        #1;
        check("R7 decade top flags", int'(tc0), 1);
        @(posedge clk);
        #1;
        check("R6 decade 9 wraps", int'(q0), 0);
        check("R9 carry into stage 1", int'(q1), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule